// File: doc/BRIEF.md
# Relative Countdown Alarm

This block is a relative alarm timer built around a mixed-radix down-counter holding days, hours, minutes and seconds. The host writes a countdown value through a small memory-mapped register port, turns the count on, and optionally unmasks the interrupt. Each single-cycle pulse on the second-tick input then removes one second from the count while counting is enabled and the count is nonzero.

When the count steps from one second down to all zeros, the block raises a sticky pending flag and the counter stays at zero. The interrupt line is the pending flag gated by the interrupt enable, so masking the interrupt hides the request without losing it. Software clears the flag by writing a one to its status bit. The read data port is registered: it returns, one clock after an address is presented, the register selected at that address.

Top module: `cdown_alarm`

## Requirements
- R1: After a synchronous reset the countdown reads 0, the run bit, the interrupt enable and the pending flag read 0, and irq is 0.
- R2: A write to offset 0x0C loads the countdown with seconds in bits [5:0], minutes in [13:8], hours in [20:16] and days (0 to 255) in [28:21]; reading 0x0C returns the live count in the same layout, with read data valid one clock after the address.
- R3: On each tick with the run bit (bit 8 of offset 0x14) set and a nonzero count, the count drops by exactly one second.
- R4: A borrow from seconds 0 reloads 59 and takes one minute; from minutes 0 reloads 59 and takes one hour; from hours 0 reloads 23 and takes one day.
- R5: With the run bit clear, or with no tick, the count does not change.
- R6: When a tick brings the count to all zeros, the pending flag (bit 0 of offset 0x1C) is set, and further ticks leave the count at zero without a new expiry.
- R7: irq is high exactly when the pending flag and the interrupt enable (bit 0 of offset 0x18) are both set; clearing the enable leaves the pending flag set.
- R8: Writing 1 to bit 0 of offset 0x1C clears the pending flag; writing 0 there leaves it unchanged.
- R9: If an expiry and a clearing write to the status register fall in the same cycle, the pending flag ends up set.
- R10: Writing zero to the countdown cancels a count in progress, and later ticks raise no pending flag.
- R11: A countdown write in the same cycle as a tick loads the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the register port |
| host_addr | input | ADDR_W | Byte offset of the register accessed |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| tick | input | 1 | One-cycle pulse marking one elapsed second |
| irq | output | 1 | Interrupt request, pending AND interrupt enable |

## Verification
The range checks on the count fields assume the host only loads legal digit values (seconds and minutes below 60, hours below 24); the stimulus writes only such values, so any out-of-range field can come only from a faulty borrow. The tick input is assumed to be a single-cycle strobe, and the bench always drives it for exactly one clock. The bench's reference model works on total seconds rather than on separate digits, so it predicts borrows independently of the counter's structure.

// File: rtl/cdalarm_pkg.sv
package cdalarm_pkg;
  // Field placement inside the countdown word (decoded by host software).
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;

  localparam logic [SEC_W-1:0] SEC_TOP = 6'd59;
  localparam logic [MIN_W-1:0] MIN_TOP = 6'd59;
  localparam logic [HR_W-1:0]  HR_TOP  = 5'd23;

  // Register offsets and control bit positions.
  localparam logic [4:0] OFS_COUNT  = 5'h0C;
  localparam logic [4:0] OFS_RUN    = 5'h14;
  localparam logic [4:0] OFS_IRQEN  = 5'h18;
  localparam logic [4:0] OFS_STATUS = 5'h1C;
  localparam int RUN_BIT = 8;
endpackage

// File: rtl/cd_counter.sv
module cd_counter
  import cdalarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run,
  input  logic              tick,
  output logic [DATA_W-1:0] cnt_word,
  output logic              expire
);
  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [HR_W-1:0]  hr_q;
  logic [DAY_W-1:0] day_q;
  logic             nonzero, last_sec, step;

  assign nonzero  = (sec_q != '0) || (min_q != '0) || (hr_q != '0) || (day_q != '0);
  assign last_sec = (sec_q == SEC_W'(1)) && (min_q == '0) && (hr_q == '0) && (day_q == '0);
  assign step     = tick && run && nonzero && !load;
  assign expire   = step && last_sec;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (load) begin
      sec_q <= load_val[SEC_LSB +: SEC_W];
      min_q <= load_val[MIN_LSB +: MIN_W];
      hr_q  <= load_val[HR_LSB  +: HR_W];
      day_q <= load_val[DAY_LSB +: DAY_W];
    end else if (step) begin
      if (sec_q != '0) begin
        sec_q <= sec_q - SEC_W'(1);
      end else begin
        sec_q <= SEC_TOP;
        if (min_q != '0) begin
          min_q <= min_q - MIN_W'(1);
        end else begin
          min_q <= MIN_TOP;
          if (hr_q != '0) begin
            hr_q <= hr_q - HR_W'(1);
          end else begin
            hr_q  <= HR_TOP;
            day_q <= day_q - DAY_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    cnt_word = '0;
    cnt_word[SEC_LSB +: SEC_W] = sec_q;
    cnt_word[MIN_LSB +: MIN_W] = min_q;
    cnt_word[HR_LSB  +: HR_W]  = hr_q;
    cnt_word[DAY_LSB +: DAY_W] = day_q;
  end

  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_q <= SEC_TOP) && (min_q <= MIN_TOP) && (hr_q <= HR_TOP));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_word));
  // R6
  zero_after_expire_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_word == '0));
  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_word == $past(cnt_word_of(load_val))));

  function automatic logic [DATA_W-1:0] cnt_word_of(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = v[SEC_LSB +: SEC_W];
    w[MIN_LSB +: MIN_W] = v[MIN_LSB +: MIN_W];
    w[HR_LSB  +: HR_W]  = v[HR_LSB  +: HR_W];
    w[DAY_LSB +: DAY_W] = v[DAY_LSB +: DAY_W];
    return w;
  endfunction
endmodule

// File: rtl/cd_ctrl.sv
module cd_ctrl
  import cdalarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] cnt_word,
  output logic              run,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  logic run_q, ie_q, pend_q, irq_q;
  logic run_d, ie_d, pend_d;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  always_comb begin
    run_d  = run_q;
    ie_d   = ie_q;
    pend_d = pend_q;
    if (wr && addr == ADDR_W'(OFS_RUN))   run_d = wdata[RUN_BIT];
    if (wr && addr == ADDR_W'(OFS_IRQEN)) ie_d  = wdata[0];
    if (wr && addr == ADDR_W'(OFS_STATUS) && wdata[0]) pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_COUNT):  rd_mux = cnt_word;
      ADDR_W'(OFS_RUN):    rd_mux[RUN_BIT] = run_q;
      ADDR_W'(OFS_IRQEN):  rd_mux[0] = ie_q;
      ADDR_W'(OFS_STATUS): rd_mux[0] = pend_q;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      ie_q    <= ie_d;
      pend_q  <= pend_d;
      irq_q   <= pend_d && ie_d;
      rdata_q <= rd_mux;
    end
  end

  assign run   = run_q;
  assign irq   = irq_q;
  assign rdata = rdata_q;

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (pend_q && ie_q));
  // R6
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(expire));
  // R9
  expiry_wins_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend_q);
endmodule

// File: rtl/cdown_alarm.sv
module cdown_alarm
  import cdalarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              tick,
  output logic              irq
);
  localparam int COUNT_MSB = DAY_LSB + DAY_W - 1;

  logic              load, run, expire;
  logic [DATA_W-1:0] cnt_word;

  assign load = host_wr && (host_addr == ADDR_W'(OFS_COUNT));

  cd_counter #(.DATA_W(DATA_W), .DAY_W(DAY_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (host_wdata),
    .run      (run),
    .tick     (tick),
    .cnt_word (cnt_word),
    .expire   (expire)
  );

  cd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (host_wr),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .expire   (expire),
    .cnt_word (cnt_word),
    .run      (run),
    .irq      (irq),
    .rdata    (host_rdata)
  );

  // R2
  layout_fit_chk: assert final (COUNT_MSB < DATA_W);
endmodule

// File: tb/test_cdown_alarm.sv
module test_cdown_alarm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [4:0]  host_addr = 5'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tick = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cdown_alarm i_cdown_alarm (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tick(tick), .irq(irq)
  );

  // Reference model: count kept as total seconds.
  int m_secs = 0;
  bit m_run = 0, m_ie = 0, m_pend = 0, m_irq = 0;
  logic [31:0] m_rdata = '0;

  function automatic logic [31:0] pack(input int d, input int h, input int m, input int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] secs_word(input int t);
    return pack(t / 86400, (t % 86400) / 3600, (t % 3600) / 60, t % 60);
  endfunction

  function automatic int word_secs(input logic [31:0] w);
    return int'(w[28:21]) * 86400 + int'(w[20:16]) * 3600 + int'(w[13:8]) * 60 + int'(w[5:0]);
  endfunction

  always @(posedge clk) begin
    logic [31:0] pre;
    bit fire;
    case (host_addr)
      5'h0C: pre = secs_word(m_secs);
      5'h14: pre = {23'd0, m_run, 8'd0};
      5'h18: pre = {31'd0, m_ie};
      5'h1C: pre = {31'd0, m_pend};
      default: pre = '0;
    endcase
    fire = 0;
    if (rst) begin
      m_secs = 0; m_run = 0; m_ie = 0; m_pend = 0; pre = '0;
    end else begin
      if (host_wr && host_addr == 5'h0C) m_secs = word_secs(host_wdata);
      else if (tick && m_run && m_secs > 0) begin
        m_secs = m_secs - 1;
        fire = (m_secs == 0);
      end
      if (host_wr && host_addr == 5'h14) m_run = host_wdata[8];
      if (host_wr && host_addr == 5'h18) m_ie = host_wdata[0];
      if (host_wr && host_addr == 5'h1C && host_wdata[0]) m_pend = 0;
      if (fire) m_pend = 1;
    end
    m_rdata = pre;
    m_irq = m_pend && m_ie;
  end

  always @(posedge clk) begin
    #2;
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL R7 cycle irq: actual=%0b expected=%0b", irq, m_irq);
    end
    total++;
    if (host_rdata !== m_rdata) begin
      bad++;
      $display("FAIL %s cycle rdata: actual=%h expected=%h", cur_req, host_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit with_tick);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d; tick = with_tick;
    @(negedge clk);
    host_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); host_addr = a;
    @(negedge clk);
    total++;
    if (host_rdata !== exp) begin
      bad++;
      $display("FAIL %s read %h: actual=%h expected=%h", req, a, host_rdata, exp);
    end
  endtask

  task automatic irq_chk(input bit exp, input string req);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq: actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    rd_chk(5'h0C, 32'h0, "R1");
    rd_chk(5'h14, 32'h0, "R1");
    rd_chk(5'h1C, 32'h0, "R1");
    irq_chk(1'b0, "R1");

    // R2 load and readback
    cur_req = "R2";
    wr(5'h0C, pack(200, 13, 45, 27), 0);
    rd_chk(5'h0C, pack(200, 13, 45, 27), "R2");

    // R3, R6: short countdown to expiry
    cur_req = "R3";
    wr(5'h0C, pack(0, 0, 0, 3), 0);
    wr(5'h14, 32'h100, 0);
    wr(5'h18, 32'h1, 0);
    ticks(1);
    rd_chk(5'h0C, pack(0, 0, 0, 2), "R3");
    cur_req = "R6";
    ticks(2);
    rd_chk(5'h1C, 32'h1, "R6");
    irq_chk(1'b1, "R6");
    ticks(3);
    rd_chk(5'h0C, 32'h0, "R6");

    // R8 write-1-to-clear
    cur_req = "R8";
    wr(5'h1C, 32'h0, 0);
    rd_chk(5'h1C, 32'h1, "R8");
    wr(5'h1C, 32'h1, 0);
    rd_chk(5'h1C, 32'h0, "R8");
    irq_chk(1'b0, "R8");

    // R4 borrow chains
    cur_req = "R4";
    wr(5'h0C, pack(1, 0, 0, 0), 0);
    ticks(1);
    rd_chk(5'h0C, pack(0, 23, 59, 59), "R4");
    wr(5'h0C, pack(0, 5, 0, 0), 0);
    ticks(1);
    rd_chk(5'h0C, pack(0, 4, 59, 59), "R4");
    wr(5'h0C, pack(3, 2, 1, 0), 0);
    ticks(2);
    rd_chk(5'h0C, pack(3, 2, 0, 58), "R4");

    // R5 no change when run bit clear
    cur_req = "R5";
    wr(5'h14, 32'h0, 0);
    ticks(4);
    rd_chk(5'h0C, pack(3, 2, 0, 58), "R5");
    rd_chk(5'h14, 32'h0, "R5");
    repeat (5) @(negedge clk);
    rd_chk(5'h0C, pack(3, 2, 0, 58), "R5");

    // R7 masking keeps pending
    cur_req = "R7";
    wr(5'h0C, pack(0, 0, 0, 1), 0);
    wr(5'h14, 32'h100, 0);
    ticks(1);
    irq_chk(1'b1, "R7");
    wr(5'h18, 32'h0, 0);
    irq_chk(1'b0, "R7");
    rd_chk(5'h1C, 32'h1, "R7");
    wr(5'h18, 32'h1, 0);
    irq_chk(1'b1, "R7");

    // R9 expiry beats clear in the same cycle
    cur_req = "R9";
    wr(5'h0C, pack(0, 0, 0, 1), 0);
    wr(5'h1C, 32'h1, 1);
    rd_chk(5'h1C, 32'h1, "R9");
    irq_chk(1'b1, "R9");
    wr(5'h1C, 32'h1, 0);

    // R10 zero write cancels
    cur_req = "R10";
    wr(5'h0C, pack(0, 0, 0, 2), 0);
    ticks(1);
    wr(5'h0C, 32'h0, 0);
    ticks(3);
    rd_chk(5'h0C, 32'h0, "R10");
    rd_chk(5'h1C, 32'h0, "R10");
    irq_chk(1'b0, "R10");

    // R11 write coincides with tick
    cur_req = "R11";
    wr(5'h0C, pack(0, 0, 7, 0), 1);
    rd_chk(5'h0C, pack(0, 0, 7, 0), "R11");

    // R1 reset mid-run
    cur_req = "R1";
    wr(5'h0C, pack(0, 0, 0, 1), 0);
    ticks(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_chk(5'h1C, 32'h0, "R1");
    rd_chk(5'h14, 32'h0, "R1");
    irq_chk(1'b0, "R1");

    repeat (2) @(negedge clk);
    report();
  end
endmodule